// File: doc/BRIEF.md
# Load-Use Hazard and Operand Forwarding Unit

This unit sits between the decode and execute stages of a short in-order scalar pipeline. It compares the source registers of the instruction being decoded with the destination of the instruction one stage ahead. When that instruction is a load whose result is not yet available, the unit raises a one-cycle stall. In the same cycle it kills the decoded instruction, so that an all-zero word, which decodes as a shift-left-logical NOP, enters execute instead. The fetch side holds its instruction and presents it again on the next cycle.

The unit also owns the decode-to-execute instruction latch. For the instruction held there, it produces the two execute operands. Each operand takes the pending writeback result when its source register matches the writeback destination, and the register file read data otherwise. Register 0 always reads as zero. Vector-class instructions take no scalar operands, so both operand outputs read as zero for them. The register file itself lies outside the unit: the unit drives the two read indices and receives the read data.

Top module: `hfu_top`

## Requirements
- R1: `stall` can be high only while `ex_is_load` is 1 and `ex_dest` is nonzero.
- R2: The rs field is `id_instr[25:21]` and the rt field is `id_instr[20:16]`. A field equal to `ex_dest` causes a hazard only when its need flag (`id_need_rs` or `id_need_rt`) is 1.
- R3: `kill` equals `stall`. After a clock edge at which `kill` was 1, `ex_instr` is 32'h0000_0000 and `ex_vector` is 0.
- R4: After a clock edge at which `kill` was 0, `ex_instr` and `ex_vector` hold the `id_instr` and `id_is_vector` values presented at that edge.
- R5: A stall lasts exactly one cycle. A hazard still present in the cycle that follows a stall does not stall again, so `stall` is never high on two consecutive cycles.
- R6: `rf_rs_addr` and `rf_rt_addr` carry bits 25:21 and 20:16 of `ex_instr`. Each operand equals `wb_result` when its source index is nonzero and equals `wb_dest`, and equals the matching `rf_*_data` otherwise.
- R7: An operand whose source index is 0 reads 32'h0000_0000, even when `wb_dest` is 0 and the register file data is nonzero.
- R8: While `ex_vector` is 1, both `op_rs` and `op_rt` read 32'h0000_0000.
- R9: While `rst_n` is low at a clock edge, the execute latch clears to a zero word with `ex_vector` 0, and the stall history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_instr | input | 32 | Instruction word in decode |
| id_need_rs | input | 1 | Decode instruction reads its rs source |
| id_need_rt | input | 1 | Decode instruction reads its rt source |
| id_is_vector | input | 1 | Decode instruction is vector-class |
| ex_dest | input | 5 | Destination of the instruction one stage ahead |
| ex_is_load | input | 1 | The instruction one stage ahead is a load |
| wb_dest | input | 5 | Destination held in the writeback latch |
| wb_result | input | 32 | Result held in the writeback latch |
| rf_rs_data | input | 32 | Register file read data at `rf_rs_addr` |
| rf_rt_data | input | 32 | Register file read data at `rf_rt_addr` |
| stall | output | 1 | Hold fetch and decode for this cycle |
| kill | output | 1 | Replace the decoded instruction with a NOP |
| ex_instr | output | 32 | Instruction word latched into execute |
| ex_vector | output | 1 | Latched instruction is vector-class |
| rf_rs_addr | output | 5 | Register file read index for rs |
| rf_rt_addr | output | 5 | Register file read index for rt |
| op_rs | output | 32 | Forwarded rs operand |
| op_rt | output | 32 | Forwarded rt operand |

## Verification
The hardest case to reach from the ports is a hazard that is still present in the cycle right after a stall. The bench holds a matching load destination and the same decode word for two edges, then checks three things: the second cycle is not flagged, the killed slot carries the zero word, and the held word enters execute on the following edge. A second difficult case is register 0 with a writeback also aimed at register 0. The bench loads a word whose source fields are zero, drives nonzero register file data and a writeback to index 0, and expects zero operands.

// File: rtl/hfu_pkg.sv
// Package: shared widths and field positions for the hazard/forwarding unit.
// Assumes a 32-register scalar file addressed by 5-bit indices.
package hfu_pkg;
    localparam int unsigned HFU_XLEN   = 32;
    localparam int unsigned HFU_RIDX   = 5;
    localparam int unsigned HFU_RS_LSB = 21;
    localparam int unsigned HFU_RT_LSB = 16;
endpackage

// File: rtl/hfu_hazard.sv
// Module: load-use hazard detector.
// Flags a stall when the instruction ahead is a load to a nonzero register
// that a needed source of the decode instruction reads. Assumes the load
// result can be forwarded one cycle later, so it never stalls twice in a row.
module hfu_hazard #(
    parameter int unsigned RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] src_rs,
    input  logic [RIDX-1:0] src_rt,
    input  logic            need_rs,
    input  logic            need_rt,
    input  logic [RIDX-1:0] ld_dest,
    input  logic            ld_valid,
    output logic            stall
);
    localparam logic [RIDX-1:0] ZERO_IDX = '0;

    logic rs_hit;
    logic rt_hit;
    logic stalled_q;

    // Purpose: compare each needed source against the pending load target.
    always_comb begin
        rs_hit = need_rs && (src_rs == ld_dest);
        rt_hit = need_rt && (src_rt == ld_dest);
        stall  = ld_valid && (ld_dest != ZERO_IDX) && (rs_hit || rt_hit) && !stalled_q;
    end

    // Purpose: remember that the previous cycle stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) stalled_q <= 1'b0;
        else        stalled_q <= stall;
    end

    assert_stall_needs_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ld_valid && ld_dest != ZERO_IDX));

    assert_stall_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_stall_has_used_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((need_rs && src_rs == ld_dest) || (need_rt && src_rt == ld_dest)));
endmodule

// File: rtl/hfu_dx_latch.sv
// Module: decode-to-execute instruction latch.
// Captures the decode word each cycle, or a zero word (NOP) when killed.
// Assumes the front end re-presents the held word after a kill.
module hfu_dx_latch #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill,
    input  logic [XLEN-1:0] in_word,
    input  logic            in_vec,
    output logic [XLEN-1:0] out_word,
    output logic            out_vec
);
    // Purpose: load the next execute instruction or a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            out_word <= '0;
            out_vec  <= 1'b0;
        end else begin
            out_word <= in_word;
            out_vec  <= in_vec;
        end
    end

    assert_kill_gives_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (out_word == '0 && !out_vec));

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !kill) |=> (out_word == $past(in_word) && out_vec == $past(in_vec)));
endmodule

// File: rtl/hfu_fwd_mux.sv
// Module: one execute operand selector.
// Index 0 yields zero; a match with the writeback target yields the
// writeback result; otherwise the register file data. A bypass (vector
// instruction) yields zero. Purely combinational.
module hfu_fwd_mux #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned RIDX = 5
) (
    input  logic [RIDX-1:0] src,
    input  logic [XLEN-1:0] rf_data,
    input  logic [RIDX-1:0] wb_dest,
    input  logic [XLEN-1:0] wb_result,
    input  logic            bypass,
    output logic [XLEN-1:0] op
);
    // Purpose: choose the operand source by priority.
    always_comb begin
        if (bypass || src == '0) op = '0;
        else if (src == wb_dest) op = wb_result;
        else                     op = rf_data;
    end
endmodule

// File: rtl/hfu_top.sv
// Module: load-use hazard and forwarding unit (top).
// Detects decode-stage load-use hazards, kills the decoded word on a stall,
// holds the execute instruction and forwards its two scalar operands.
// Assumes an external register file read combinationally at rf_*_addr.
module hfu_top
    import hfu_pkg::*;
#(
    parameter int unsigned XLEN   = HFU_XLEN,
    parameter int unsigned RIDX   = HFU_RIDX,
    parameter int unsigned RS_LSB = HFU_RS_LSB,
    parameter int unsigned RT_LSB = HFU_RT_LSB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] id_instr,
    input  logic            id_need_rs,
    input  logic            id_need_rt,
    input  logic            id_is_vector,
    input  logic [RIDX-1:0] ex_dest,
    input  logic            ex_is_load,
    input  logic [RIDX-1:0] wb_dest,
    input  logic [XLEN-1:0] wb_result,
    input  logic [XLEN-1:0] rf_rs_data,
    input  logic [XLEN-1:0] rf_rt_data,
    output logic            stall,
    output logic            kill,
    output logic [XLEN-1:0] ex_instr,
    output logic            ex_vector,
    output logic [RIDX-1:0] rf_rs_addr,
    output logic [RIDX-1:0] rf_rt_addr,
    output logic [XLEN-1:0] op_rs,
    output logic [XLEN-1:0] op_rt
);
    localparam int unsigned NSRC = 2;

    logic [RIDX-1:0] src_idx [NSRC];
    logic [XLEN-1:0] rf_in   [NSRC];
    logic [XLEN-1:0] op_out  [NSRC];

    hfu_hazard #(.RIDX(RIDX)) u_hazard (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_rs   (id_instr[RS_LSB +: RIDX]),
        .src_rt   (id_instr[RT_LSB +: RIDX]),
        .need_rs  (id_need_rs),
        .need_rt  (id_need_rt),
        .ld_dest  (ex_dest),
        .ld_valid (ex_is_load),
        .stall    (stall)
    );

    // Purpose: a stall always discards the decoded word.
    always_comb kill = stall;

    hfu_dx_latch #(.XLEN(XLEN)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (kill),
        .in_word  (id_instr),
        .in_vec   (id_is_vector),
        .out_word (ex_instr),
        .out_vec  (ex_vector)
    );

    // Purpose: route register indices and read data per source.
    always_comb begin
        src_idx[0] = ex_instr[RS_LSB +: RIDX];
        src_idx[1] = ex_instr[RT_LSB +: RIDX];
        rf_in[0]   = rf_rs_data;
        rf_in[1]   = rf_rt_data;
        rf_rs_addr = src_idx[0];
        rf_rt_addr = src_idx[1];
        op_rs      = op_out[0];
        op_rt      = op_out[1];
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_fwd
        hfu_fwd_mux #(.XLEN(XLEN), .RIDX(RIDX)) u_mux (
            .src       (src_idx[g]),
            .rf_data   (rf_in[g]),
            .wb_dest   (wb_dest),
            .wb_result (wb_result),
            .bypass    (ex_vector),
            .op        (op_out[g])
        );
    end

    assert_reg0_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rs_addr == '0) |-> (op_rs == '0));

    assert_vector_no_operands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_vector |-> (op_rs == '0 && op_rt == '0));

    assert_forward_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_vector && rf_rt_addr != '0 && rf_rt_addr == wb_dest) |-> (op_rt == wb_result));
endmodule

// File: tb/hfu_top_bench.sv
module hfu_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NHZ = 9;
    // {need_rs, need_rt, is_load, exp_stall, rs[4:0], rt[4:0], dest[4:0]}
    localparam logic [18:0] HZ_TAB [NHZ] = '{
        {1'b1, 1'b0, 1'b1, 1'b1, 5'd3,  5'd4,  5'd3},
        {1'b0, 1'b1, 1'b1, 1'b0, 5'd3,  5'd4,  5'd3},
        {1'b0, 1'b1, 1'b1, 1'b1, 5'd8,  5'd7,  5'd7},
        {1'b0, 1'b1, 1'b0, 1'b0, 5'd8,  5'd7,  5'd7},
        {1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  5'd2,  5'd0},
        {1'b1, 1'b1, 1'b1, 1'b0, 5'd5,  5'd1,  5'd6},
        {1'b1, 1'b1, 1'b1, 1'b1, 5'd9,  5'd9,  5'd9},
        {1'b0, 1'b0, 1'b1, 1'b0, 5'd2,  5'd2,  5'd2},
        {1'b0, 1'b1, 1'b1, 1'b1, 5'd1,  5'd31, 5'd31}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] id_instr = '0;
    logic id_need_rs = 1'b0, id_need_rt = 1'b0, id_is_vector = 1'b0;
    logic [4:0] ex_dest = '0, wb_dest = '0;
    logic ex_is_load = 1'b0;
    logic [31:0] wb_result = '0, rf_rs_data = '0, rf_rt_data = '0;
    logic stall, kill, ex_vector;
    logic [31:0] ex_instr, op_rs, op_rt;
    logic [4:0] rf_rs_addr, rf_rt_addr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hfu_top u_hfu_top (
        .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_need_rs(id_need_rs),
        .id_need_rt(id_need_rt), .id_is_vector(id_is_vector), .ex_dest(ex_dest),
        .ex_is_load(ex_is_load), .wb_dest(wb_dest), .wb_result(wb_result),
        .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data), .stall(stall), .kill(kill),
        .ex_instr(ex_instr), .ex_vector(ex_vector), .rf_rs_addr(rf_rs_addr),
        .rf_rt_addr(rf_rt_addr), .op_rs(op_rs), .op_rt(op_rt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance one edge; inputs may change and outputs are sampled afterwards
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] lo);
        return {6'h23, rs, rt, lo};
    endfunction

    // load a word into execute with no hazard
    task automatic load_ex(input logic [31:0] w, input logic vec);
        ex_is_load = 1'b0;
        id_instr = w;
        id_is_vector = vec;
        step();
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        id_instr = 32'hFFFF_FFFF;
        id_is_vector = 1'b1;
        step();
        step();
        check("R9 reset ex_instr", ex_instr, 32'h0);
        check("R9 reset ex_vector", {31'b0, ex_vector}, 32'h0);
        check("R9 reset stall", {31'b0, stall}, 32'h0);
        id_is_vector = 1'b0;
        rst_n = 1'b1;
        step();

        // table walk: R1 R2 combinational hazard, then R3/R4 latch result
        for (int i = 0; i < NHZ; i++) begin
            logic [18:0] v;
            logic [31:0] w;
            v = HZ_TAB[i];
            w = mk(v[14:10], v[9:5], 16'h1000 + 16'(i));
            id_need_rs = v[18];
            id_need_rt = v[17];
            ex_is_load = v[16];
            ex_dest = v[4:0];
            id_instr = w;
            #1;
            check("R1 R2 stall", {31'b0, stall}, {31'b0, v[15]});
            check("R3 kill follows stall", {31'b0, kill}, {31'b0, v[15]});
            step();
            check("R3 R4 latch", ex_instr, v[15] ? 32'h0 : w);
            ex_is_load = 1'b0;
            step();
        end

        // R5: hazard held across two edges stalls only once
        id_need_rs = 1'b1; id_need_rt = 1'b0;
        id_instr = mk(5'd12, 5'd1, 16'h5555);
        id_is_vector = 1'b1;
        ex_is_load = 1'b1; ex_dest = 5'd12;
        #1;
        check("R5 first stall", {31'b0, stall}, 32'h1);
        step();
        check("R3 bubble word", ex_instr, 32'h0);
        check("R3 bubble vector", {31'b0, ex_vector}, 32'h0);
        check("R5 no repeat stall", {31'b0, stall}, 32'h0);
        step();
        check("R4 held word enters", ex_instr, mk(5'd12, 5'd1, 16'h5555));
        check("R4 vector flag", {31'b0, ex_vector}, 32'h1);
        ex_is_load = 1'b0;
        id_is_vector = 1'b0;

        // R6 forwarding
        load_ex(mk(5'd5, 5'd6, 16'h0), 1'b0);
        rf_rs_data = 32'h1111_1111; rf_rt_data = 32'h2222_2222;
        wb_result = 32'hCAFE_0001; wb_dest = 5'd5;
        #1;
        check("R6 rs addr", {27'b0, rf_rs_addr}, 32'd5);
        check("R6 rt addr", {27'b0, rf_rt_addr}, 32'd6);
        check("R6 rs forwarded", op_rs, 32'hCAFE_0001);
        check("R6 rt from file", op_rt, 32'h2222_2222);
        wb_dest = 5'd6;
        #1;
        check("R6 rs from file", op_rs, 32'h1111_1111);
        check("R6 rt forwarded", op_rt, 32'hCAFE_0001);
        wb_dest = 5'd17;
        #1;
        check("R6 no match rs", op_rs, 32'h1111_1111);

        // R7 register 0 with writeback to 0
        load_ex(mk(5'd0, 5'd0, 16'h7), 1'b0);
        rf_rs_data = 32'hDEAD_BEEF; rf_rt_data = 32'hBEEF_DEAD;
        wb_dest = 5'd0; wb_result = 32'h1234_5678;
        #1;
        check("R7 rs zero", op_rs, 32'h0);
        check("R7 rt zero", op_rt, 32'h0);

        // R8 vector instruction
        load_ex(mk(5'd5, 5'd6, 16'h9), 1'b1);
        wb_dest = 5'd5;
        #1;
        check("R8 vector rs", op_rs, 32'h0);
        check("R8 vector rt", op_rt, 32'h0);

        // R9 reset mid-run clears latch
        rst_n = 1'b0;
        step();
        check("R9 reset clears latch", ex_instr, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule